// File: doc/BRIEF.md
# Recursive Leading-Zero Counter

This block is a purely combinational priority encoder. It reports how many zero bits come before the first set bit of a word of 2^K bits, scanning from the most significant end. A floating-point adder uses this count as the left-shift distance that normalizes a difference after cancellation. The count is K+1 bits wide, so a word with no set bit can report the full width.

The word is handled as a balanced tree. Each pair of adjacent bits becomes a two-bit count in a small leaf cell. Each higher level joins two neighbouring counts of width W into one count of width W+1. If the upper neighbour's count has its top bit set, that neighbour holds only zeros, and the joined count is half the span plus the lower neighbour's count. Otherwise the upper count passes through unchanged. Adding half the span touches only the two top bit positions, so no carry chain is needed at any level.

Top module: `lzc_top`

## Requirements
- R1: For any word that is not all zero, `lz_o` equals the number of zero bits above the highest set bit, with bit N-1 treated as the first position scanned.
- R2: An all-zero word gives `lz_o` = N (=2^K), so only bit K of the output is 1.
- R3: When bit N-1 of `word_i` is 1, `lz_o` is 0 whatever the other bits hold.
- R4: With K=2, the word 4'b0010 gives `lz_o` = 3'b010.
- R5: Bits below the highest set bit have no effect: a word whose highest set bit is at index i gives N-1-i, for any content of bits i-1..0.
- R6: When the upper N/2 bits are all zero, `lz_o` equals N/2 plus the count of the lower half alone; otherwise it equals the count of the upper half alone.
- R7: The output is exactly K+1 bits wide, and the block is valid for every K from 1 to 6.
- R8: With K=1, `lz_o` is 0 for 2'b1x, 1 for 2'b01 and 2 for 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| word_i | input | 2^K | Word to scan; bit 2^K-1 is scanned first |
| lz_o | output | K+1 | Number of leading zero bits, 0 to 2^K |

## Verification
The bench builds five copies of the block, with K set to 1, 2, 3, 4 and 6, and drives them all from one shared stimulus word. The copies with K of 4 or less receive every 16-bit pattern. This covers every leaf case, every merge select and every carry into the top output bit exhaustively at those widths. The 64-bit copy depends on the same merge logic, which repeats across six levels. It receives directed walking single-one words with noise placed below the set bit, half-split words, and random words shifted right by random amounts, so that long runs of leading zeros occur as often as short ones.

// File: rtl/lzc_pkg.sv
package lzc_pkg;

  // Bit offset, inside the flat level bus, of the counts for tree level lvl.
  // Level j (j >= 1) holds n >> j counts, each j+1 bits wide.
  function automatic int lvl_base(input int n, input int lvl);
    int acc;
    acc = 0;
    for (int i = 1; i < lvl; i++) begin
      acc += (n >> i) * (i + 1);
    end
    return acc;
  endfunction

endpackage

// File: rtl/lzc_leaf2.sv
// Leaf cell: leading-zero count of a two-bit slice (0, 1 or 2).
module lzc_leaf2 (
  input  logic       hi_i,
  input  logic       lo_i,
  output logic [1:0] cnt_o
);

  always_comb begin
    cnt_o[1] = ~hi_i & ~lo_i;
    cnt_o[0] = ~hi_i &  lo_i;
  end

endmodule

// File: rtl/lzc_merge.sv
// Joins the counts of two neighbouring slices of 2^(W-1) bits each.
// The top bit of the upper count flags an all-zero upper slice.
module lzc_merge #(
  parameter int W = 2
) (
  input  logic [W-1:0] upper_cnt_i,
  input  logic [W-1:0] lower_cnt_i,
  output logic [W:0]   cnt_o
);

  logic         upper_empty;
  logic [W:0]   lower_plus_half;

  always_comb begin
    upper_empty = upper_cnt_i[W-1];
    // Adding 2^(W-1): only the top two positions change, no carry chain.
    lower_plus_half = {lower_cnt_i[W-1], ~lower_cnt_i[W-1], lower_cnt_i[W-2:0]};
    if (upper_empty) begin
      cnt_o = lower_plus_half;
    end else begin
      cnt_o = {1'b0, upper_cnt_i};
    end
  end

endmodule

// File: rtl/lzc_top.sv
module lzc_top #(
  parameter  int K = 5,
  localparam int N = 1 << K
) (
  input  logic [N-1:0] word_i,
  output logic [K:0]   lz_o
);

  localparam int TOTAL_W = lzc_pkg::lvl_base(N, K + 1);
  localparam int TOP_OFS = lzc_pkg::lvl_base(N, K);

  // All tree levels packed one after another; level j starts at lvl_base(N, j).
  logic [TOTAL_W-1:0] lvl_bus;

  // Level 1: leaf cells on bit pairs, group 0 at the most significant end.
  for (genvar g = 0; g < N / 2; g++) begin : g_leaf
    lzc_leaf2 u_leaf (
      .hi_i  (word_i[N-1-2*g]),
      .lo_i  (word_i[N-2-2*g]),
      .cnt_o (lvl_bus[2*g +: 2])
    );
  end

  // Levels 2..K: each joins two neighbours of the level below.
  for (genvar j = 2; j <= K; j++) begin : g_lvl
    localparam int PREV_OFS = lzc_pkg::lvl_base(N, j - 1);
    localparam int CUR_OFS  = lzc_pkg::lvl_base(N, j);
    for (genvar g = 0; g < (N >> j); g++) begin : g_node
      lzc_merge #(.W(j)) u_merge (
        .upper_cnt_i (lvl_bus[PREV_OFS + (2*g)*j +: j]),
        .lower_cnt_i (lvl_bus[PREV_OFS + (2*g+1)*j +: j]),
        .cnt_o       (lvl_bus[CUR_OFS + g*(j+1) +: j+1])
      );
    end
  end

  assign lz_o = lvl_bus[TOP_OFS +: K+1];

endmodule

// File: rtl/lzc_top_chk.sv
module lzc_top_chk #(
  parameter  int K = 5,
  localparam int N = 1 << K
) (
  input logic [N-1:0] word_i,
  input logic [K:0]   lz_o
);

  always_comb begin
    // R7
    lz_range_chk: assert (int'(lz_o) <= N);
    if (word_i == '0) begin
      // R2
      zero_word_chk: assert (lz_o == {1'b1, {K{1'b0}}});
    end
    if (word_i[N-1]) begin
      // R3
      msb_set_chk: assert (lz_o == '0);
    end
    if (word_i != '0) begin
      // R1
      first_one_chk: assert ((word_i << lz_o) >> (N - 1) == 1);
      // R5
      lead_clear_chk: assert ((word_i >> (N - int'(lz_o))) == '0);
    end
  end

endmodule

bind lzc_top lzc_top_chk #(.K(K)) u_chk (
  .word_i (word_i),
  .lz_o   (lz_o)
);

// File: tb/tb_lzc_top.sv
`timescale 1ns/1ps
module tb_lzc_top;

  logic        clk;
  logic [63:0] stim;
  logic [6:0]  lz64;
  logic [1:0]  lz2;
  logic [2:0]  lz4;
  logic [3:0]  lz8;
  logic [4:0]  lz16;
  int          vectors;
  int          miscmp;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  lzc_top #(.K(6)) dut    (.word_i(stim),       .lz_o(lz64));
  lzc_top #(.K(1)) dut_k1 (.word_i(stim[1:0]),  .lz_o(lz2));
  lzc_top #(.K(2)) dut_k2 (.word_i(stim[3:0]),  .lz_o(lz4));
  lzc_top #(.K(3)) dut_k3 (.word_i(stim[7:0]),  .lz_o(lz8));
  lzc_top #(.K(4)) dut_k4 (.word_i(stim[15:0]), .lz_o(lz16));

  function automatic int ref_lz(input logic [63:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      if (w[i]) return n - 1 - i;
    end
    return n;
  endfunction

  function automatic string tag_for(input logic [63:0] w, input int n);
    logic [63:0] m;
    m = (n == 64) ? '1 : ((64'd1 << n) - 1);
    if ((w & m) == '0) return "R2";
    if (w[n-1]) return "R3";
    return "R1";
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscmp++;
      $display("FAIL %s actual=%0d expected=%0d word=%h", tag, act, exp, stim);
    end
  endtask

  task automatic apply(input logic [63:0] w);
    @(negedge clk);
    stim = w;
    #2;
  endtask

  task automatic t_idle();
    apply('0);
    chk("R2 idle k6", lz64, 64);
    chk("R2 idle k1", lz2, 2);
    chk("R2 idle k4", lz16, 16);
  endtask

  task automatic t_width();
    chk("R7 width k1", $bits(lz2), 2);
    chk("R7 width k2", $bits(lz4), 3);
    chk("R7 width k3", $bits(lz8), 4);
    chk("R7 width k4", $bits(lz16), 5);
    chk("R7 width k6", $bits(lz64), 7);
  endtask

  task automatic t_leaf_k1();
    apply(64'h3); chk("R8 11", lz2, 0);
    apply(64'h2); chk("R8 10", lz2, 0);
    apply(64'h1); chk("R8 01", lz2, 1);
    apply(64'h0); chk("R8 00", lz2, 2);
  endtask

  task automatic t_example();
    apply(64'h2);
    chk("R4 0010", lz4, 2);
  endtask

  task automatic t_exhaustive();
    for (int v = 0; v < 65536; v++) begin
      apply(64'(v));
      chk({tag_for(stim, 2),  " k1"}, lz2,  ref_lz(stim, 2));
      chk({tag_for(stim, 4),  " k2"}, lz4,  ref_lz(stim, 4));
      chk({tag_for(stim, 8),  " k3"}, lz8,  ref_lz(stim, 8));
      chk({tag_for(stim, 16), " k4"}, lz16, ref_lz(stim, 16));
      if (stim[15:8] == '0) begin
        chk("R6 k4 low half", lz16, 8 + ref_lz({56'd0, stim[7:0]}, 8));
      end else begin
        chk("R6 k4 high half", lz16, ref_lz({56'd0, stim[15:8]}, 8));
      end
    end
  endtask

  task automatic t_single_one();
    for (int i = 0; i < 64; i++) begin
      logic [63:0] below;
      below = (i == 0) ? '0 : ({$urandom, $urandom} & ((64'd1 << i) - 1));
      apply((64'd1 << i) | below);
      chk("R5 walking one", lz64, 63 - i);
      apply(64'd1 << i);
      chk("R5 clean one", lz64, 63 - i);
    end
  endtask

  task automatic t_halves();
    for (int t = 0; t < 200; t++) begin
      logic [31:0] lo;
      logic [31:0] hi;
      lo = $urandom >> ($urandom % 33);
      hi = $urandom >> ($urandom % 32);
      apply({32'd0, lo});
      chk("R6 k6 upper empty", lz64, 32 + ref_lz({32'd0, lo}, 32));
      if (hi == '0) hi = 32'd1;
      apply({hi, lo});
      chk("R6 k6 upper used", lz64, ref_lz({32'd0, hi}, 32));
    end
  endtask

  task automatic t_random();
    for (int t = 0; t < 3000; t++) begin
      logic [63:0] w;
      w = {$urandom, $urandom} >> ($urandom % 65);
      apply(w);
      chk({tag_for(w, 64), " k6 random"}, lz64, ref_lz(w, 64));
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    miscmp++;
    $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    vectors = 0;
    miscmp  = 0;
    stim    = '0;
    t_idle();
    t_width();
    t_leaf_k1();
    t_example();
    t_single_one();
    t_halves();
    t_exhaustive();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

endmodule